// File: doc/BRIEF.md
# Wait-State Memory Slave with Burst Pause Handling

This block is an AHB-Lite slave that fronts a small word-organised register array. Real transfers (NONSEQ and SEQ) can be slowed by a wait-state count that a configuration input sets. BUSY and IDLE transfers always get a response in the same cycle with no wait. A master can therefore pause an undefined-length incrementing burst with BUSY cycles and can close the burst straight from a BUSY cycle.

The slave captures the control signals of an address phase only on a rising edge where HREADY is high. The captured transfer type then controls everything in the data phase that follows: whether the wait counter is loaded, whether the array is read or written, and which byte lanes a write touches.

Top module: `ahbl_pause_slave`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0 (OKAY) and hrdata is zero, because the captured transfer type is IDLE.
- R2: Control inputs are captured only on a rising edge where hready is 1. A NONSEQ write that is presented while hready is 0, and then withdrawn, leaves the array unchanged.
- R3: When a NONSEQ (htrans=2'b10) or SEQ (htrans=2'b11) address phase is captured with cfg_wait=N, hreadyout stays 0 for exactly N cycles of the data phase and then goes to 1.
- R4: The data phase of a captured BUSY (htrans=2'b01) address phase has hreadyout=1 and hresp=0 in its first cycle, even when cfg_wait is non-zero and the cycle falls in the middle of a waited burst.
- R5: A BUSY data phase neither reads nor writes. hrdata is zero in that phase, and hwdata presented in it is not stored.
- R6: A burst may end from a BUSY cycle. A NONSEQ that follows a BUSY cycle is a fresh transfer: it gets the full cfg_wait wait states and uses its own address. BUSY appears only with a burst type other than SINGLE (hburst=3'b000).
- R7: IDLE (htrans=2'b00) transfers, and address phases with hsel=0, get a zero-wait OKAY data phase and do not access the array.
- R8: A write stores hwdata on the edge where its data phase completes with hready=1. hsize selects the lanes: 0 writes byte lane haddr[1:0], 1 writes the halfword at lanes {haddr[1],0} and {haddr[1],1}, and 2 writes all four lanes. Other lanes keep their value.
- R9: In the data phase of a read, hrdata shows the whole word addressed by haddr[7:2].
- R10: hresp is 0 (OKAY) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W (8) | Byte address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 for a write |
| hsize | input | 3 | Transfer size (byte, halfword, word) |
| hburst | input | 3 | Burst type |
| hwdata | input | DATA_W (32) | Write data |
| hready | input | 1 | Bus-wide ready; 1 completes the current phase |
| cfg_wait | input | WAIT_W (4) | Wait states added to each real transfer |
| hrdata | output | DATA_W (32) | Read data |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | Response, always OKAY |

## Verification
The block is driven with single transfers at zero and at several non-zero wait counts. This separates the timing of the wait counter from the data path. Incrementing bursts with one or more BUSY cycles, where one burst ends from BUSY into a NONSEQ and another ends into IDLE, show whether wait insertion follows the captured type or leaks into pause cycles. Byte and halfword writes that are read back as full words expose lane selection. A write offered while an outside stall holds hready low, and cycles with hsel low, show that nothing is captured except on a ready edge.

// File: rtl/ahbl_pause_pkg.sv
package ahbl_pause_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BURST_SINGLE = 3'b000;

    function automatic logic moves_data(input trans_e t);
        return (t == TR_NONSEQ) || (t == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahbl_pause_capture.sv
module ahbl_pause_capture
    import ahbl_pause_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic              hready,
    output trans_e            dp_kind,
    output logic              dp_write,
    output logic [ADDR_W-1:0] dp_addr,
    output logic [2:0]        dp_size
);

    typedef struct packed {
        trans_e              kind;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [2:0]          size;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (hready) begin
            cap_d.kind = hsel ? trans_e'(htrans) : TR_IDLE;
            cap_d.wr   = hwrite;
            cap_d.addr = haddr;
            cap_d.size = hsize;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            cap_q <= '{kind: TR_IDLE, wr: 1'b0, addr: '0, size: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign dp_kind  = cap_q.kind;
    assign dp_write = cap_q.wr;
    assign dp_addr  = cap_q.addr;
    assign dp_size  = cap_q.size;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready |=> $stable(cap_q)); // R2

endmodule

// File: rtl/ahbl_pause_waitgen.sv
module ahbl_pause_waitgen #(
    parameter int WAIT_W = 4
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hready,
    input  logic              xfer_go,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              ready_o
);

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } wait_t;

    wait_t wt_d, wt_q;

    always_comb begin
        wt_d = wt_q;
        if (hready) begin
            wt_d.cnt = xfer_go ? cfg_wait : '0;
        end else if (wt_q.cnt != '0) begin
            wt_d.cnt = wt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            wt_q <= '{cnt: '0};
        end else begin
            wt_q <= wt_d;
        end
    end

    assign ready_o = (wt_q.cnt == '0);

    AST_NO_WAIT_WITHOUT_XFER: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && !xfer_go) |=> ready_o); // R7

endmodule

// File: rtl/ahbl_pause_store.sv
module ahbl_pause_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              dp_active,
    input  logic              dp_write,
    input  logic [ADDR_W-1:0] dp_addr,
    input  logic [2:0]        dp_size,
    input  logic              hready,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata
);

    localparam int NBYTES = DATA_W / 8;
    localparam int LSB_W  = $clog2(NBYTES);
    localparam int IDX_W  = ADDR_W - LSB_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic [NBYTES-1:0] lane_en;
    int                span;
    int                base;

    assign idx = dp_addr[ADDR_W-1:LSB_W];

    always_comb begin
        span = (int'(dp_size) >= LSB_W) ? NBYTES : (1 << dp_size);
        base = int'(dp_addr[LSB_W-1:0]) & ~(span - 1);
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_en[b] = (b >= base) && (b < base + span);
    end

    always_comb begin
        mem_d = mem_q;
        if (dp_active && dp_write && hready) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (lane_en[b]) begin
                    mem_d[idx][8*b +: 8] = hwdata[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign hrdata = (dp_active && !dp_write) ? mem_q[idx] : '0;

endmodule

// File: rtl/ahbl_pause_slave.sv
module ahbl_pause_slave
    import ahbl_pause_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp
);

    trans_e            dp_kind;
    logic              dp_write;
    logic [ADDR_W-1:0] dp_addr;
    logic [2:0]        dp_size;
    logic              dp_active;
    logic              xfer_go;

    assign xfer_go   = hsel && moves_data(trans_e'(htrans));
    assign dp_active = moves_data(dp_kind);

    ahbl_pause_capture #(.ADDR_W(ADDR_W)) u_capture (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .hsel     (hsel),
        .haddr    (haddr),
        .htrans   (htrans),
        .hwrite   (hwrite),
        .hsize    (hsize),
        .hready   (hready),
        .dp_kind  (dp_kind),
        .dp_write (dp_write),
        .dp_addr  (dp_addr),
        .dp_size  (dp_size)
    );

    ahbl_pause_waitgen #(.WAIT_W(WAIT_W)) u_waitgen (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .hready   (hready),
        .xfer_go  (xfer_go),
        .cfg_wait (cfg_wait),
        .ready_o  (hreadyout)
    );

    ahbl_pause_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .dp_active (dp_active),
        .dp_write  (dp_write),
        .dp_addr   (dp_addr),
        .dp_size   (dp_size),
        .hready    (hready),
        .hwdata    (hwdata),
        .hrdata    (hrdata)
    );

    assign hresp = 1'b0;

    AST_BUSY_ZERO_WAIT: assert property (@(posedge hclk) disable iff (!hresetn)
        (dp_kind == TR_BUSY) |-> (hreadyout && !hresp)); // R4

    AST_BUSY_NO_DATA: assert property (@(posedge hclk) disable iff (!hresetn)
        (dp_kind == TR_BUSY) |-> (hrdata == '0)); // R5

    AST_WAIT_ENTERED: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && xfer_go && (cfg_wait != '0)) |=> !hreadyout); // R3

    AST_BUSY_IN_BURST: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready && (htrans == 2'b01)) |-> (hburst != BURST_SINGLE)); // R6

endmodule

// File: tb/ahbl_pause_slave_test.sv
`timescale 1ns/1ps
module ahbl_pause_slave_test;

    localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [7:0]  haddr = '0;
    logic [1:0]  htrans = T_IDLE;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [2:0]  hburst = 3'b000;
    logic [31:0] hwdata = '0;
    logic        stall = 1'b0;
    logic [3:0]  cfg_wait = '0;
    logic        hready;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    assign hready = stall ? 1'b0 : hreadyout;

    always #4 hclk = ~hclk;

    ahbl_pause_slave uut (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hready(hready),
        .cfg_wait(cfg_wait), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    // scoreboard queues, one entry per cycle
    bit          q_rdy [$];
    logic [31:0] q_dat [$];
    string       q_req [$];
    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model
    logic [31:0] model_mem [64];
    bit          m_act = 0, m_wr = 0;
    logic [7:0]  m_addr = '0;
    logic [2:0]  m_size = '0;
    int          m_wait = 0;
    logic [31:0] pend_wd = '0;

    function automatic void model_write(logic [7:0] a, logic [2:0] sz, logic [31:0] wd);
        logic [3:0] lanes;
        case (sz)
            3'd0:    lanes = 4'b0001 << a[1:0];
            3'd1:    lanes = a[1] ? 4'b1100 : 4'b0011;
            default: lanes = 4'b1111;
        endcase
        for (int b = 0; b < 4; b++)
            if (lanes[b]) model_mem[a[7:2]][8*b +: 8] = wd[8*b +: 8];
    endfunction

    task automatic cyc(input bit st, input bit sel, input logic [1:0] tr, input bit wr,
                       input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd,
                       output bit acc);
        bit er;
        hsel = sel; htrans = tr; hwrite = wr; haddr = a; hsize = sz; hwdata = wd; stall = st;
        er = (m_wait == 0);
        q_rdy.push_back(er);
        q_dat.push_back((m_act && !m_wr) ? model_mem[m_addr[7:2]] : 32'h0);
        q_req.push_back(cur_req);
        acc = er && !st;
        @(posedge hclk);
        if (acc) begin
            if (m_act && m_wr) model_write(m_addr, m_size, wd);
            m_act = sel && tr[1]; m_wr = wr; m_addr = a; m_size = sz;
            m_wait = m_act ? int'(cfg_wait) : 0;
        end else if (m_wait > 0) begin
            m_wait--;
        end
        #1;
    endtask

    task automatic beat(input bit sel, input logic [1:0] tr, input bit wr,
                        input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd);
        bit acc;
        do cyc(1'b0, sel, tr, wr, a, sz, pend_wd, acc); while (!acc);
        pend_wd = wd;
    endtask

    task automatic idle_beat();
        beat(1'b0, T_IDLE, 1'b0, 8'h00, 3'd2, 32'h0);
    endtask

    // monitor
    bit          e_rdy;
    logic [31:0] e_dat;
    string       e_req;
    always @(negedge hclk) begin
        if (q_rdy.size() > 0) begin
            e_rdy = q_rdy.pop_front();
            e_dat = q_dat.pop_front();
            e_req = q_req.pop_front();
            vectors++;
            if (hreadyout !== e_rdy || hrdata !== e_dat || hresp !== 1'b0) begin
                fails++;
                if (hresp !== 1'b0)
                    $display("FAIL R10 (%s) hresp actual %b expected 0", e_req, hresp);
                else
                    $display("FAIL %s hreadyout/hrdata actual %b/%h expected %b/%h",
                             e_req, hreadyout, hrdata, e_rdy, e_dat);
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model_mem[i] = '0;
        repeat (3) @(posedge hclk);
        #1 hresetn = 1'b1;

        cur_req = "R1";
        idle_beat();

        // R8, R9: zero-wait word writes and reads
        cur_req = "R8";
        cfg_wait = 4'd0;
        beat(1, T_NSEQ, 1, 8'h00, 3'd2, 32'h1111_2222);
        beat(1, T_NSEQ, 1, 8'h04, 3'd2, 32'hA5A5_5A5A);
        cur_req = "R9";
        beat(1, T_NSEQ, 0, 8'h00, 3'd2, 32'h0);
        beat(1, T_NSEQ, 0, 8'h04, 3'd2, 32'h0);
        idle_beat();

        // R3: waited transfers at several counts
        cur_req = "R3";
        for (int w = 1; w <= 5; w += 2) begin
            cfg_wait = 4'(w);
            beat(1, T_NSEQ, 1, 8'h10, 3'd2, 32'hC0DE_0000 + 32'(w));
            beat(1, T_NSEQ, 0, 8'h10, 3'd2, 32'h0);
            idle_beat();
        end

        // R8: byte and halfword lanes
        cur_req = "R8";
        cfg_wait = 4'd1;
        beat(1, T_NSEQ, 1, 8'h05, 3'd0, 32'h0000_EE00);
        beat(1, T_NSEQ, 1, 8'h06, 3'd1, 32'h7788_0000);
        beat(1, T_NSEQ, 1, 8'h01, 3'd1, 32'h0000_3344);
        beat(1, T_NSEQ, 0, 8'h04, 3'd2, 32'h0);
        beat(1, T_NSEQ, 0, 8'h00, 3'd2, 32'h0);
        idle_beat();

        // R4, R5, R6: write burst paused with BUSY, ended from BUSY into NONSEQ
        cfg_wait = 4'd3;
        hburst = 3'b001;
        cur_req = "R4";
        beat(1, T_NSEQ, 1, 8'h20, 3'd2, 32'hAAAA_0001);
        beat(1, T_BUSY, 1, 8'h24, 3'd2, 32'hDEAD_BEEF);
        beat(1, T_BUSY, 1, 8'h24, 3'd2, 32'hDEAD_BEEF);
        cur_req = "R5";
        beat(1, T_SEQ,  1, 8'h24, 3'd2, 32'hAAAA_0002);
        beat(1, T_BUSY, 1, 8'h28, 3'd2, 32'hBAD0_BAD0);
        cur_req = "R6";
        beat(1, T_NSEQ, 0, 8'h20, 3'd2, 32'h0);
        beat(1, T_BUSY, 0, 8'h24, 3'd2, 32'h0);
        cur_req = "R5";
        beat(1, T_SEQ,  0, 8'h24, 3'd2, 32'h0);
        beat(1, T_BUSY, 0, 8'h28, 3'd2, 32'h0);
        cur_req = "R6";
        beat(1, T_NSEQ, 0, 8'h28, 3'd2, 32'h0);
        beat(1, T_BUSY, 0, 8'h2C, 3'd2, 32'h0);
        idle_beat();
        hburst = 3'b000;

        // R7: IDLE with select, and NONSEQ write with hsel low
        cur_req = "R7";
        beat(1, T_IDLE, 1, 8'h00, 3'd2, 32'hFFFF_FFFF);
        beat(0, T_NSEQ, 1, 8'h00, 3'd2, 32'hFFFF_FFFF);
        idle_beat();
        beat(1, T_NSEQ, 0, 8'h00, 3'd2, 32'h0);
        idle_beat();

        // R2: write offered while hready is held low elsewhere, then withdrawn
        cur_req = "R2";
        cfg_wait = 4'd0;
        begin
            bit acc;
            cyc(1'b1, 1, T_NSEQ, 1, 8'h30, 3'd2, pend_wd, acc);
        end
        beat(1, T_IDLE, 0, 8'h30, 3'd2, 32'h1234_5678);
        beat(1, T_NSEQ, 0, 8'h30, 3'd2, 32'h0);
        idle_beat();
        idle_beat();

        repeat (2) @(negedge hclk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge hclk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before end of stimulus");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule